// File: doc/BRIEF.md
# Per-CPU Prioritised Interrupt Selector

This block sits beside an interrupt distributor and serves a small number of processors. For every CPU it scans all interrupts that are enabled and pending for that CPU and picks a winner: the lowest numeric priority, with ties going to the lowest id. The winner is published as that CPU's highest-pending id when it passes the CPU's priority mask. The CPU's request line is raised when the winner also beats the priority of the interrupt the CPU is already handling. Interrupt ids 0 to 31 have a separate priority for each CPU. Ids from 32 upward have one priority shared by all CPUs.

Each CPU reaches the block through a small register window, selected by `regCpu`. Offset 0x00 is the interface enable (bit 0). Offset 0x04 is the priority mask (8 bits). Offset 0x0C is a read that acknowledges the winner. Offset 0x10 is a write that signals end-of-interrupt, with the id in bits 9:0. Offset 0x14 reads back the running priority. Offset 0x18 reads back the highest-pending id. The id 1023 means "none". A running priority of 0x100 means idle.

An acknowledge makes the interrupt running and remembers which interrupt it preempted. End-of-interrupt then brings that interrupt back, or removes a completed interrupt from the middle of the nesting chain. The pending bits belong to the distributor. The block only sends it one-cycle clear and set requests.

Top module: `irq_prio_selector`

## Requirements
- R1: After reset, each CPU reads these values: priority mask 0xF0, running priority 0x100, highest-pending id 1023, interface enable 0. Every request line is low.
- R2: The highest-pending id is the enabled, pending interrupt with the lowest priority value. When several share that value, the lowest id wins.
- R3: A winner is reported at offset 0x18 only if its priority is less than or equal to the CPU's mask. Otherwise 1023 is read and the line stays low.
- R4: A CPU's request line is high only if the reported winner's priority is strictly below that CPU's running priority.
- R5: When the global distributor enable or the CPU's interface enable is 0, that CPU's line is low and offset 0x18 reads 1023.
- R6: Reading offset 0x0C returns 1023 and changes nothing in two cases: there is no reported winner, or the winner's priority is not strictly below the running priority.
- R7: A successful acknowledge returns the winner's id and makes it running, with its priority as the running priority. For an interrupt in the per-CPU model, it pulses `pendClr` bit cpu*NUM_IRQ+id for the acknowledging CPU only.
- R8: When `irqOneOfN` is set for the acknowledged interrupt, the acknowledge pulses `pendClr` for that id on every CPU.
- R9: End-of-interrupt for the running id restores the interrupt it preempted as running. The running priority becomes that interrupt's priority, or 0x100 when there was none.
- R10: End-of-interrupt while the running id is 1023 has no effect: no pending request and no change of running priority.
- R11: End-of-interrupt for an id that is in the nesting chain but not running removes it from the chain. The running priority is unchanged, and a later completion skips the removed id.
- R12: At end-of-interrupt, an id that is level-sensitive (`irqEdge`=0), enabled, asserted and targeted at this CPU is made pending again. This is a single `pendSet` pulse for this CPU only.
- R13: Ids below 32 use the per-CPU priority of the CPU being served. Ids of 32 and above use the shared priority.
- R14: Only bit 0 of the interface enable and bits 7:0 of the mask are kept. Writing 0 to bit 0 disables the CPU's interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| distEnable | input | 1 | Global distributor enable |
| irqEnable | input | NUM_IRQ | Per-interrupt enable |
| irqPending | input | NUM_CPU*NUM_IRQ | Pending bit, index cpu*NUM_IRQ+id |
| irqLevel | input | NUM_IRQ | Current level of each interrupt input |
| irqEdge | input | NUM_IRQ | 1 = edge-triggered, 0 = level-sensitive |
| irqOneOfN | input | NUM_IRQ | 1 = one CPU handles it for all |
| irqTarget | input | NUM_CPU*NUM_IRQ | Target bit, index cpu*NUM_IRQ+id |
| privPrio | input | NUM_CPU*PRIV_IRQ*8 | Per-CPU priority of ids below PRIV_IRQ, byte (cpu*PRIV_IRQ+id) |
| sharedPrio | input | (NUM_IRQ-PRIV_IRQ)*8 | Shared priority, byte (id-PRIV_IRQ) |
| regSel | input | 1 | Register access strobe, one cycle |
| regWr | input | 1 | 1 = write, 0 = read |
| regCpu | input | CPU_W | CPU whose interface is accessed |
| regAddr | input | 8 | Byte offset |
| regWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after the read |
| cpuIrq | output | NUM_CPU | Interrupt request line per CPU |
| pendClr | output | NUM_CPU*NUM_IRQ | One-cycle pending-clear requests |
| pendSet | output | NUM_CPU*NUM_IRQ | One-cycle pending-set requests |

## Verification
The assertions run on every cycle. They check that the lines drop whenever the distributor is disabled, that clear requests come only from acknowledge reads, and that set requests come only from end-of-interrupt writes, one bit at a time. They also check that acknowledge and running-priority readbacks stay within their legal ranges. Some behaviours only the bench scenarios can show, because they depend on history: tie-breaking, mask boundaries, per-CPU against shared priorities, the one-of-N clear, and level re-pending. The same holds for nested preemption, where completions out of order must restore the right predecessor.

// File: rtl/irq_prio_selector_pkg.sv
package irq_prio_selector_pkg;
  localparam int ID_W      = 10;
  localparam int PRIO_W    = 8;
  localparam int RPRIO_W   = PRIO_W + 1;
  localparam int CPU_IDX_W = 4;
  localparam logic [ID_W-1:0]    NO_IRQ     = 10'd1023;
  localparam logic [RPRIO_W-1:0] IDLE_PRIO  = 9'h100;
  localparam logic [PRIO_W-1:0]  MASK_RESET = 8'hF0;

  typedef enum logic [7:0] {
    OFF_CTL    = 8'h00,
    OFF_MASK   = 8'h04,
    OFF_ACK    = 8'h0C,
    OFF_EOI    = 8'h10,
    OFF_RUNPRI = 8'h14,
    OFF_HIPEND = 8'h18
  } reg_off_e;

  // Strobes from control to datapath, all qualified by cpu.
  typedef struct packed {
    logic                 cfgEn;
    logic                 cfgMask;
    logic                 runLoad;
    logic [CPU_IDX_W-1:0] cpu;
    logic [ID_W-1:0]      runId;
    logic [PRIO_W-1:0]    data;
  } sel_strobe_t;
endpackage

// File: rtl/irq_prio_selector_datapath.sv
module irq_prio_selector_datapath
  import irq_prio_selector_pkg::*;
#(
  parameter int NUM_CPU  = 2,
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               distEnable,
  input  logic [NUM_IRQ-1:0]                 irqEnable,
  input  logic [NUM_CPU*NUM_IRQ-1:0]         irqPending,
  input  logic [NUM_CPU*PRIV_IRQ*PRIO_W-1:0] privPrio,
  input  logic [(NUM_IRQ-PRIV_IRQ)*PRIO_W-1:0] sharedPrio,
  input  sel_strobe_t                        strb,
  output logic [NUM_CPU-1:0]                 cpuEn,
  output logic [NUM_CPU*PRIO_W-1:0]          prioMask,
  output logic [NUM_CPU*ID_W-1:0]            runId,
  output logic [NUM_CPU*RPRIO_W-1:0]         runPrio,
  output logic [NUM_CPU*ID_W-1:0]            hpId,
  output logic [NUM_CPU*RPRIO_W-1:0]         hpPrio,
  output logic [NUM_CPU-1:0]                 cpuIrq
);

  // Priority of an id as seen by one CPU; out-of-range ids read as idle.
  function automatic logic [RPRIO_W-1:0] prioOf(input int cpu, input int id);
    if (id < PRIV_IRQ)
      return {1'b0, privPrio[(cpu*PRIV_IRQ+id)*PRIO_W +: PRIO_W]};
    else if (id < NUM_IRQ)
      return {1'b0, sharedPrio[(id-PRIV_IRQ)*PRIO_W +: PRIO_W]};
    else
      return IDLE_PRIO;
  endfunction

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [RPRIO_W-1:0] bestP, curP, runPrioR, hpPrioR;
    logic [ID_W-1:0]    bestI, runIdR, hpIdR;
    logic [PRIO_W-1:0]  maskR;
    logic               enR, irqR, live, passMask;
    logic               hit;

    assign hit = strb.cpu == CPU_IDX_W'(c);

    // Linear scan: strict compare keeps the lowest id on a tie.
    always_comb begin
      bestP = IDLE_PRIO;
      bestI = NO_IRQ;
      for (int i = 0; i < NUM_IRQ; i++) begin
        curP = prioOf(c, i);
        if (irqEnable[i] && irqPending[c*NUM_IRQ+i] && curP < bestP) begin
          bestP = curP;
          bestI = ID_W'(i);
        end
      end
    end

    assign live     = distEnable && enR;
    assign passMask = bestP <= {1'b0, maskR};

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enR      <= 1'b0;
        maskR    <= MASK_RESET;
        runIdR   <= NO_IRQ;
        runPrioR <= IDLE_PRIO;
        hpIdR    <= NO_IRQ;
        hpPrioR  <= IDLE_PRIO;
        irqR     <= 1'b0;
      end else begin
        if (strb.cfgEn && hit)   enR   <= strb.data[0];
        if (strb.cfgMask && hit) maskR <= strb.data;
        if (strb.runLoad && hit) begin
          runIdR   <= strb.runId;
          runPrioR <= prioOf(c, int'(strb.runId));
        end
        hpIdR   <= (live && passMask) ? bestI : NO_IRQ;
        hpPrioR <= (live && passMask) ? bestP : IDLE_PRIO;
        irqR    <= live && passMask && (bestP < runPrioR);
      end
    end

    assign cpuEn[c]                         = enR;
    assign prioMask[c*PRIO_W +: PRIO_W]     = maskR;
    assign runId[c*ID_W +: ID_W]            = runIdR;
    assign runPrio[c*RPRIO_W +: RPRIO_W]    = runPrioR;
    assign hpId[c*ID_W +: ID_W]             = hpIdR;
    assign hpPrio[c*RPRIO_W +: RPRIO_W]     = hpPrioR;
    assign cpuIrq[c]                        = irqR;
  end

endmodule

// File: rtl/irq_prio_selector_control.sv
module irq_prio_selector_control
  import irq_prio_selector_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64,
  parameter int CPU_W   = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       regSel,
  input  logic                       regWr,
  input  logic [CPU_W-1:0]           regCpu,
  input  logic [7:0]                 regAddr,
  input  logic [31:0]                regWdata,
  input  logic [NUM_IRQ-1:0]         irqEnable,
  input  logic [NUM_IRQ-1:0]         irqLevel,
  input  logic [NUM_IRQ-1:0]         irqEdge,
  input  logic [NUM_IRQ-1:0]         irqOneOfN,
  input  logic [NUM_CPU*NUM_IRQ-1:0] irqTarget,
  input  logic [NUM_CPU-1:0]         cpuEn,
  input  logic [NUM_CPU*PRIO_W-1:0]  prioMask,
  input  logic [NUM_CPU*ID_W-1:0]    runId,
  input  logic [NUM_CPU*RPRIO_W-1:0] runPrio,
  input  logic [NUM_CPU*ID_W-1:0]    hpId,
  input  logic [NUM_CPU*RPRIO_W-1:0] hpPrio,
  output sel_strobe_t                strb,
  output logic [31:0]                rdData,
  output logic                       rdValid,
  output logic [NUM_CPU*NUM_IRQ-1:0] pendClr,
  output logic [NUM_CPU*NUM_IRQ-1:0] pendSet
);
  localparam int IDX_W = $clog2(NUM_IRQ);

  logic [ID_W-1:0]    pred    [NUM_CPU][NUM_IRQ];
  logic [NUM_IRQ-1:0] onChain [NUM_CPU];

  logic               isRd, isWr, ackOk, eoiGo, eoiRunning, eoiInRange, unlink, repend;
  logic [ID_W-1:0]    curRun, curHp, eoiId;
  logic [RPRIO_W-1:0] curRunP, curHpP;
  logic [IDX_W-1:0]   runIdx, hpIdx, eoiIdx;
  logic [NUM_CPU*NUM_IRQ-1:0] clrNext, setNext;
  logic [31:0]        rdNext;

  assign isRd    = regSel && !regWr;
  assign isWr    = regSel && regWr;
  assign curRun  = runId[regCpu*ID_W +: ID_W];
  assign curHp   = hpId[regCpu*ID_W +: ID_W];
  assign curRunP = runPrio[regCpu*RPRIO_W +: RPRIO_W];
  assign curHpP  = hpPrio[regCpu*RPRIO_W +: RPRIO_W];
  assign runIdx  = curRun[IDX_W-1:0];
  assign hpIdx   = curHp[IDX_W-1:0];
  assign eoiId   = regWdata[ID_W-1:0];
  assign eoiIdx  = eoiId[IDX_W-1:0];

  assign ackOk      = isRd && regAddr == OFF_ACK && curHp != NO_IRQ && curHpP < curRunP;
  assign eoiGo      = isWr && regAddr == OFF_EOI && curRun != NO_IRQ;
  assign eoiRunning = eoiGo && eoiId == curRun;
  assign eoiInRange = eoiId < ID_W'(NUM_IRQ);
  assign unlink     = eoiGo && !eoiRunning && eoiInRange && onChain[regCpu][eoiIdx];
  assign repend     = eoiGo && eoiInRange && !irqEdge[eoiIdx] && irqEnable[eoiIdx]
                      && irqLevel[eoiIdx] && irqTarget[regCpu*NUM_IRQ + eoiIdx];

  always_comb begin
    strb         = '0;
    strb.cpu     = CPU_IDX_W'(regCpu);
    strb.data    = regWdata[PRIO_W-1:0];
    strb.cfgEn   = isWr && regAddr == OFF_CTL;
    strb.cfgMask = isWr && regAddr == OFF_MASK;
    strb.runLoad = ackOk || eoiRunning;
    strb.runId   = ackOk ? curHp : pred[regCpu][runIdx];
  end

  always_comb begin
    clrNext = '0;
    setNext = '0;
    if (ackOk)
      for (int c = 0; c < NUM_CPU; c++)
        if (irqOneOfN[hpIdx] || c == int'(regCpu))
          clrNext[c*NUM_IRQ + int'(hpIdx)] = 1'b1;
    if (repend)
      setNext[int'(regCpu)*NUM_IRQ + int'(eoiIdx)] = 1'b1;
  end

  always_comb begin
    case (regAddr)
      OFF_CTL:    rdNext = {31'b0, cpuEn[regCpu]};
      OFF_MASK:   rdNext = {24'b0, prioMask[regCpu*PRIO_W +: PRIO_W]};
      OFF_ACK:    rdNext = {22'b0, ackOk ? curHp : NO_IRQ};
      OFF_RUNPRI: rdNext = {23'b0, curRunP};
      OFF_HIPEND: rdNext = {22'b0, curHp};
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      pendClr <= '0;
      pendSet <= '0;
      for (int c = 0; c < NUM_CPU; c++) begin
        onChain[c] <= '0;
        for (int j = 0; j < NUM_IRQ; j++) pred[c][j] <= NO_IRQ;
      end
    end else begin
      rdValid <= isRd;
      if (isRd) rdData <= rdNext;
      pendClr <= clrNext;
      pendSet <= setNext;
      if (ackOk) begin
        pred[regCpu][hpIdx]    <= curRun;
        onChain[regCpu][hpIdx] <= 1'b1;
      end
      if (eoiRunning) onChain[regCpu][runIdx] <= 1'b0;
      if (unlink) begin
        onChain[regCpu][eoiIdx] <= 1'b0;
        for (int j = 0; j < NUM_IRQ; j++)
          if (onChain[regCpu][j] && pred[regCpu][j] == eoiId)
            pred[regCpu][j] <= pred[regCpu][eoiIdx];
      end
    end
  end

endmodule

// File: rtl/irq_prio_selector.sv
module irq_prio_selector
  import irq_prio_selector_pkg::*;
#(
  parameter int NUM_CPU  = 2,
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 distEnable,
  input  logic [NUM_IRQ-1:0]                   irqEnable,
  input  logic [NUM_CPU*NUM_IRQ-1:0]           irqPending,
  input  logic [NUM_IRQ-1:0]                   irqLevel,
  input  logic [NUM_IRQ-1:0]                   irqEdge,
  input  logic [NUM_IRQ-1:0]                   irqOneOfN,
  input  logic [NUM_CPU*NUM_IRQ-1:0]           irqTarget,
  input  logic [NUM_CPU*PRIV_IRQ*PRIO_W-1:0]   privPrio,
  input  logic [(NUM_IRQ-PRIV_IRQ)*PRIO_W-1:0] sharedPrio,
  input  logic                                 regSel,
  input  logic                                 regWr,
  input  logic [CPU_W-1:0]                     regCpu,
  input  logic [7:0]                           regAddr,
  input  logic [31:0]                          regWdata,
  output logic [31:0]                          rdData,
  output logic                                 rdValid,
  output logic [NUM_CPU-1:0]                   cpuIrq,
  output logic [NUM_CPU*NUM_IRQ-1:0]           pendClr,
  output logic [NUM_CPU*NUM_IRQ-1:0]           pendSet
);
  sel_strobe_t               strb;
  logic [NUM_CPU-1:0]         cpuEn;
  logic [NUM_CPU*PRIO_W-1:0]  prioMask;
  logic [NUM_CPU*ID_W-1:0]    runId, hpId;
  logic [NUM_CPU*RPRIO_W-1:0] runPrio, hpPrio;

  irq_prio_selector_datapath #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .PRIV_IRQ(PRIV_IRQ)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .distEnable(distEnable), .irqEnable(irqEnable),
    .irqPending(irqPending), .privPrio(privPrio), .sharedPrio(sharedPrio),
    .strb(strb), .cpuEn(cpuEn), .prioMask(prioMask), .runId(runId),
    .runPrio(runPrio), .hpId(hpId), .hpPrio(hpPrio), .cpuIrq(cpuIrq)
  );

  irq_prio_selector_control #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .CPU_W(CPU_W)
  ) ctl_i (
    .clk(clk), .rst_n(rst_n), .regSel(regSel), .regWr(regWr), .regCpu(regCpu),
    .regAddr(regAddr), .regWdata(regWdata), .irqEnable(irqEnable),
    .irqLevel(irqLevel), .irqEdge(irqEdge), .irqOneOfN(irqOneOfN),
    .irqTarget(irqTarget), .cpuEn(cpuEn), .prioMask(prioMask), .runId(runId),
    .runPrio(runPrio), .hpId(hpId), .hpPrio(hpPrio), .strb(strb),
    .rdData(rdData), .rdValid(rdValid), .pendClr(pendClr), .pendSet(pendSet)
  );
endmodule

// File: rtl/irq_prio_selector_chk.sv
module irq_prio_selector_chk
  import irq_prio_selector_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_IRQ = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       distEnable,
  input logic                       regSel,
  input logic                       regWr,
  input logic [7:0]                 regAddr,
  input logic [31:0]                rdData,
  input logic                       rdValid,
  input logic [NUM_CPU-1:0]         cpuIrq,
  input logic [NUM_CPU*NUM_IRQ-1:0] pendClr,
  input logic [NUM_CPU*NUM_IRQ-1:0] pendSet
);
  AST_DIST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !distEnable |=> cpuIrq == '0); // R5
  AST_CLR_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pendClr != '0) |-> $past(regSel && !regWr && regAddr == OFF_ACK)); // R7
  AST_SET_FROM_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    (pendSet != '0) |-> $past(regSel && regWr && regAddr == OFF_EOI)); // R12
  AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pendSet)); // R12
  AST_ACK_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && $past(regAddr == OFF_ACK)) |-> (rdData == 32'd1023 || rdData < NUM_IRQ)); // R6
  AST_RUNPRI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && $past(regAddr == OFF_RUNPRI)) |-> rdData <= 32'h100); // R9
  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && $past(regAddr == OFF_MASK)) |-> rdData[31:8] == '0); // R14
endmodule

bind irq_prio_selector irq_prio_selector_chk #(.NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ)) chk_i (
  .clk(clk), .rst_n(rst_n), .distEnable(distEnable), .regSel(regSel), .regWr(regWr),
  .regAddr(regAddr), .rdData(rdData), .rdValid(rdValid), .cpuIrq(cpuIrq),
  .pendClr(pendClr), .pendSet(pendSet)
);

// File: tb/irq_prio_selector_tb_top.sv
`timescale 1ns/1ps
module irq_prio_selector_tb_top;
  localparam int NC = 2;
  localparam int NI = 64;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic distEnable = 1'b0;
  logic [NI-1:0] irqEnable = '1, irqLevel = '0, irqEdge = '1, irqOneOfN = '0;
  logic [NC*NI-1:0] irqTarget = '1, pendState, tbSet = '0;
  logic [NC*NP*8-1:0] privPrio;
  logic [(NI-NP)*8-1:0] sharedPrio;
  logic [7:0] pp [NC][NP];
  logic [7:0] sp [NI-NP];
  logic regSel = 1'b0, regWr = 1'b0;
  logic [0:0] regCpu = '0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] rdData;
  logic rdValid;
  logic [NC-1:0] cpuIrq;
  logic [NC*NI-1:0] pendClr, pendSet;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NP; i++) privPrio[(c*NP+i)*8 +: 8] = pp[c][i];
    for (int i = 0; i < NI-NP; i++) sharedPrio[i*8 +: 8] = sp[i];
  end

  // Distributor model: applies the block's requests and bench injections.
  always @(posedge clk)
    if (!rst_n) pendState <= '0;
    else pendState <= (pendState & ~pendClr) | pendSet | tbSet;

  irq_prio_selector #(.NUM_CPU(NC), .NUM_IRQ(NI), .PRIV_IRQ(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .distEnable(distEnable), .irqEnable(irqEnable),
    .irqPending(pendState), .irqLevel(irqLevel), .irqEdge(irqEdge),
    .irqOneOfN(irqOneOfN), .irqTarget(irqTarget), .privPrio(privPrio),
    .sharedPrio(sharedPrio), .regSel(regSel), .regWr(regWr), .regCpu(regCpu),
    .regAddr(regAddr), .regWdata(regWdata), .rdData(rdData), .rdValid(rdValid),
    .cpuIrq(cpuIrq), .pendClr(pendClr), .pendSet(pendSet)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when read data comes back.
  always @(negedge clk)
    if (rdValid) begin
      if (expQ.size() == 0) checkVal("unexpected read data", int'(rdData), -1);
      else checkVal(tagQ.pop_front(), int'(rdData), expQ.pop_front());
    end

  task automatic access(input int cpu, input bit wr, input int addr, input int wdata);
    @(negedge clk);
    regSel = 1'b1; regWr = wr; regCpu = cpu[0:0]; regAddr = addr[7:0]; regWdata = wdata;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input int cpu, input int addr, input int exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    access(cpu, 1'b0, addr, 0);
  endtask

  task automatic wr(input int cpu, input int addr, input int data);
    access(cpu, 1'b1, addr, data);
  endtask

  task automatic setPend(input int cpu, input int id);
    @(negedge clk);
    tbSet[cpu*NI+id] = 1'b1;
    @(negedge clk);
    tbSet = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    for (int c = 0; c < NC; c++) for (int i = 0; i < NP; i++) pp[c][i] = 8'h80;
    for (int i = 0; i < NI-NP; i++) sp[i] = 8'h80;
    pp[0][5] = 8'h50; pp[1][5] = 8'h10;
    sp[40-NP] = 8'h30; sp[45-NP] = 8'h30; sp[50-NP] = 8'h20;
    sp[52-NP] = 8'h10; sp[55-NP] = 8'h05; sp[60-NP] = 8'h08;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    checkVal("R1 lines low", int'(cpuIrq), 0);
    rd(0, 8'h04, 32'hF0, "R1 mask reset");
    rd(0, 8'h14, 32'h100, "R1 running prio reset");
    rd(0, 8'h18, 1023, "R1 highest pending reset");
    rd(1, 8'h00, 0, "R1 interface disabled");

    distEnable = 1'b1;
    wr(0, 8'h00, 1);
    wr(1, 8'h00, 1);
    wr(0, 8'h04, 32'h1FF);
    rd(0, 8'h04, 32'hFF, "R14 mask keeps 8 bits");
    wr(1, 8'h04, 32'hFF);

    // R2 lowest value then lowest id
    setPend(0, 45); setPend(0, 40); setPend(0, 5);
    rd(0, 8'h18, 40, "R2 tie to lowest id");
    checkVal("R4 line up when idle", int'(cpuIrq[0]), 1);

    // R13 per-CPU priority for low ids
    setPend(1, 5); setPend(1, 40);
    rd(1, 8'h18, 5, "R13 cpu1 private priority");
    rd(0, 8'h18, 40, "R13 cpu0 private priority");

    // R3 mask boundary
    wr(0, 8'h04, 32'h20);
    rd(0, 8'h18, 1023, "R3 masked out");
    checkVal("R3 line low when masked", int'(cpuIrq[0]), 0);
    wr(0, 8'h04, 32'h30);
    rd(0, 8'h18, 40, "R3 equal to mask passes");
    wr(0, 8'h04, 32'hFF);

    // R5 disables
    distEnable = 1'b0;
    settle();
    checkVal("R5 lines low dist off", int'(cpuIrq), 0);
    rd(0, 8'h18, 1023, "R5 hp none dist off");
    distEnable = 1'b1;
    wr(1, 8'h00, 0);
    rd(1, 8'h18, 1023, "R5 hp none cpu off");
    checkVal("R5 cpu1 line low", int'(cpuIrq[1]), 0);
    wr(1, 8'h00, 1);
    checkVal("R4 cpu0 line back", int'(cpuIrq[0]), 1);

    // R7 acknowledge, per-CPU clear
    rd(0, 8'h0C, 40, "R7 ack id");
    checkVal("R7 cpu0 pending cleared", int'(pendState[40]), 0);
    checkVal("R7 cpu1 pending kept", int'(pendState[NI+40]), 1);
    rd(0, 8'h14, 32'h30, "R7 running prio");
    checkVal("R4 equal prio no line", int'(cpuIrq[0]), 0);
    rd(0, 8'h18, 45, "R4 hp still reported");
    rd(0, 8'h0C, 1023, "R6 ack not better");
    rd(0, 8'h14, 32'h30, "R6 running prio unchanged");

    // Nesting
    setPend(0, 50);
    checkVal("R4 preempting line", int'(cpuIrq[0]), 1);
    rd(0, 8'h0C, 50, "R7 nested ack 50");
    rd(0, 8'h14, 32'h20, "R7 running prio 50");
    setPend(0, 52);
    rd(0, 8'h0C, 52, "R7 nested ack 52");
    rd(0, 8'h14, 32'h10, "R7 running prio 52");

    // R11 unlink, R9 restore
    wr(0, 8'h10, 50);
    rd(0, 8'h14, 32'h10, "R11 running unchanged");
    wr(0, 8'h10, 52);
    rd(0, 8'h14, 32'h30, "R11 R9 restore skips 50");
    wr(0, 8'h10, 40);
    rd(0, 8'h14, 32'h100, "R9 idle after last");

    // R10 EOI with nothing running
    irqEdge[60] = 1'b0;
    irqLevel[60] = 1'b1;
    wr(0, 8'h10, 60);
    checkVal("R10 no repend when idle", int'(pendState[60]), 0);
    rd(0, 8'h14, 32'h100, "R10 running prio idle");

    // R12 level re-pend
    setPend(0, 60);
    rd(0, 8'h0C, 60, "R12 ack level irq");
    checkVal("R12 cleared by ack", int'(pendState[60]), 0);
    wr(0, 8'h10, 60);
    checkVal("R12 repended this cpu", int'(pendState[60]), 1);
    checkVal("R12 other cpu untouched", int'(pendState[NI+60]), 0);
    rd(0, 8'h0C, 60, "R12 ack again");
    irqLevel[60] = 1'b0;
    wr(0, 8'h10, 60);
    checkVal("R12 no repend when low", int'(pendState[60]), 0);

    // R8 one-of-N
    irqOneOfN[55] = 1'b1;
    setPend(0, 55); setPend(1, 55);
    rd(1, 8'h18, 55, "R8 cpu1 sees 55");
    rd(0, 8'h0C, 55, "R8 cpu0 ack 55");
    checkVal("R8 cpu0 cleared", int'(pendState[55]), 0);
    checkVal("R8 cpu1 cleared", int'(pendState[NI+55]), 0);
    rd(1, 8'h18, 5, "R8 cpu1 next winner");
    wr(0, 8'h10, 55);

    // R14 interface enable bit 0
    checkVal("R14 cpu1 line before", int'(cpuIrq[1]), 1);
    wr(1, 8'h00, 2);
    checkVal("R14 cpu1 line off", int'(cpuIrq[1]), 0);
    rd(1, 8'h00, 0, "R14 enable reads 0");

    settle();
    checkVal("scoreboard drained", expQ.size(), 0);
    finishRun();
  end
endmodule